// File: doc/BRIEF.md
# Dual-Mode Subword Mantissa Multiplier

This block multiplies two mantissa operands in one of two modes chosen by a mode input. In wide mode the full 53-bit operands give one 106-bit product. In split mode the same array forms two separate 24×24-bit products, one per lane. The caller packs both lanes into the wide operand words ahead of the block. The two narrow products come out in fixed fields of the 106-bit result word.

Each partial-product bit is a plain AND of one multiplicand bit and one multiplier bit. Every bit that lies outside both narrow lanes is also gated by the mode. In split mode those cross terms are therefore zero, and no carry can cross from one lane into the other. Operand A has one unused bit between its two lanes. That bit leaves a spare product bit between the two narrow results, so a later adder has room for a carry. The product is registered and appears one clock after the operands and the mode are sampled. A parameter can remove the register and make the block purely combinational.

Top module: `dual_lane_mant_mul`

## Requirements
- R1: With `wide_mode` = 1, `product` equals the full unsigned product `op_a[52:0] * op_b[52:0]` across bits [105:0].
- R2: With `wide_mode` = 0, `product[47:0]` equals `op_a[23:0] * op_b[23:0]`.
- R3: With `wide_mode` = 0, `product[96:49]` equals `op_a[48:25] * op_b[47:24]`.
- R4: With `wide_mode` = 0, `product[48]` and `product[105:97]` are zero.
- R5: With `wide_mode` = 0, the bits `op_a[24]`, `op_a[52:49]` and `op_b[52:48]` have no effect on `product`.
- R6: With `wide_mode` = 0 and both lanes all ones, each lane field holds exactly (2^24-1)^2, and bit 48 stays zero, so no carry leaks between lanes.
- R7: `product` reflects the inputs sampled at the previous rising clock edge and holds between edges. While `rst_n` is low it is zero.
- R8: The mode may change on every cycle, and each result follows the mode that was sampled with its own operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the result register |
| wide_mode | input | 1 | 1 = one 53×53 product, 0 = two 24×24 lane products |
| op_a | input | 53 | Multiplicand; in split mode lanes at [23:0] and [48:25] |
| op_b | input | 53 | Multiplier; in split mode lanes at [23:0] and [47:24] |
| product | output | 106 | Product word; in split mode lanes at [47:0] and [96:49] |

## Verification
The checks assume that `wide_mode`, `op_a` and `op_b` are known, non-X values at every sampled edge after reset. They also assume the unsigned arithmetic above, with no other operand format. The stimulus meets these assumptions by driving every input from time zero and changing inputs only at falling edges. Random values fill all 53 operand bits, including the separator and upper bits that split mode must ignore. Directed cases add all-ones lanes, all-ones wide operands and zeros, and mode toggling on consecutive cycles.

// File: rtl/mmul_pkg.sv
package mmul_pkg;

  // Strobes from mode decode to the partial-product array
  typedef struct packed {
    logic crossEn;  // bits outside both narrow lanes
    logic lowEn;    // bits inside the low lane region
    logic highEn;   // bits inside the high lane region
  } laneCtrl_t;

endpackage

// File: rtl/mmul_ctrl.sv
module mmul_ctrl
  import mmul_pkg::*;
(
  input  logic      wideMode,
  output laneCtrl_t ctrl
);

  always_comb begin
    ctrl         = '0;
    ctrl.crossEn = wideMode;
    ctrl.lowEn   = 1'b1;
    ctrl.highEn  = 1'b1;
  end

endmodule

// File: rtl/mmul_pp_array.sv
module mmul_pp_array
  import mmul_pkg::*;
#(
  parameter int WIDE_W = 53,
  parameter int LANE_W = 24
) (
  input  logic [WIDE_W-1:0]             opA,
  input  logic [WIDE_W-1:0]             opB,
  input  laneCtrl_t                     ctrl,
  output logic [WIDE_W-1:0][WIDE_W-1:0] ppRows
);

  // Lane regions, in operand bit positions
  localparam int LoEnd   = LANE_W;          // low lane: [LANE_W-1:0] in both
  localparam int HiALo   = LANE_W + 1;      // high lane of A after separator bit
  localparam int HiAHi   = 2 * LANE_W;
  localparam int HiBLo   = LANE_W;
  localparam int HiBHi   = 2 * LANE_W - 1;

  for (genvar j = 0; j < WIDE_W; j++) begin : g_row
    for (genvar i = 0; i < WIDE_W; i++) begin : g_col
      if (i < LoEnd && j < LoEnd) begin : g_low
        assign ppRows[j][i] = opA[i] & opB[j] & ctrl.lowEn;
      end else if (i >= HiALo && i <= HiAHi && j >= HiBLo && j <= HiBHi) begin : g_high
        assign ppRows[j][i] = opA[i] & opB[j] & ctrl.highEn;
      end else begin : g_cross
        assign ppRows[j][i] = opA[i] & opB[j] & ctrl.crossEn;
      end
    end
  end

endmodule

// File: rtl/mmul_reducer.sv
module mmul_reducer #(
  parameter int WIDE_W  = 53,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [WIDE_W-1:0][WIDE_W-1:0] ppRows,
  output logic [2*WIDE_W-1:0]           prodOut
);

  localparam int ProdW = 2 * WIDE_W;

  logic [ProdW-1:0] sumComb;

  // Shift-and-add of AND rows; no recoding, so no sign or lane fix-up terms
  always_comb begin
    sumComb = '0;
    for (int j = 0; j < WIDE_W; j++) begin
      sumComb = sumComb + (ProdW'(ppRows[j]) << j);
    end
  end

  if (OUT_REG) begin : g_reg
    logic [ProdW-1:0] prodQ;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prodQ <= '0;
      else        prodQ <= sumComb;
    end
    assign prodOut = prodQ;
  end else begin : g_comb
    assign prodOut = sumComb;
  end

endmodule

// File: rtl/dual_lane_mant_mul.sv
module dual_lane_mant_mul
  import mmul_pkg::*;
#(
  parameter int WIDE_W  = 53,
  parameter int LANE_W  = 24,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wide_mode,
  input  logic [WIDE_W-1:0]   op_a,
  input  logic [WIDE_W-1:0]   op_b,
  output logic [2*WIDE_W-1:0] product
);

  laneCtrl_t                     laneCtrl;
  logic [WIDE_W-1:0][WIDE_W-1:0] ppRows;

  mmul_ctrl u_ctrl (
    .wideMode (wide_mode),
    .ctrl     (laneCtrl)
  );

  mmul_pp_array #(.WIDE_W(WIDE_W), .LANE_W(LANE_W)) u_array (
    .opA    (op_a),
    .opB    (op_b),
    .ctrl   (laneCtrl),
    .ppRows (ppRows)
  );

  mmul_reducer #(.WIDE_W(WIDE_W), .OUT_REG(OUT_REG)) u_reduce (
    .clk     (clk),
    .rst_n   (rst_n),
    .ppRows  (ppRows),
    .prodOut (product)
  );

endmodule

// File: rtl/dual_lane_mant_mul_chk.sv
module dual_lane_mant_mul_chk #(
  parameter int WIDE_W  = 53,
  parameter int LANE_W  = 24,
  parameter bit OUT_REG = 1'b1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wide_mode,
  input logic [WIDE_W-1:0]   op_a,
  input logic [WIDE_W-1:0]   op_b,
  input logic [2*WIDE_W-1:0] product
);

  localparam int ProdW  = 2 * WIDE_W;
  localparam int LprodW = 2 * LANE_W;
  localparam int HiOff  = 2 * LANE_W + 1;

  logic              expValid;
  logic              expWide;
  logic [WIDE_W-1:0] expA;
  logic [WIDE_W-1:0] expB;

  if (OUT_REG) begin : g_delay
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        expValid <= 1'b0;
        expWide  <= 1'b0;
        expA     <= '0;
        expB     <= '0;
      end else begin
        expValid <= 1'b1;
        expWide  <= wide_mode;
        expA     <= op_a;
        expB     <= op_b;
      end
    end

    // R7: result register cleared by reset
    assert_reset_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !expValid |-> product == '0);
  end else begin : g_direct
    assign expValid = 1'b1;
    assign expWide  = wide_mode;
    assign expA     = op_a;
    assign expB     = op_b;
  end

  assert_wide_product_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (expValid && expWide) |-> product == ProdW'(expA) * ProdW'(expB));

  assert_low_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (expValid && !expWide) |->
      product[LprodW-1:0] == LprodW'(expA[LANE_W-1:0]) * LprodW'(expB[LANE_W-1:0]));

  assert_high_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (expValid && !expWide) |->
      product[HiOff+LprodW-1:HiOff] ==
        LprodW'(expA[2*LANE_W:LANE_W+1]) * LprodW'(expB[2*LANE_W-1:LANE_W]));

  assert_lane_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (expValid && !expWide) |->
      (product[LprodW] == 1'b0 && product[ProdW-1:HiOff+LprodW] == '0));

endmodule

bind dual_lane_mant_mul dual_lane_mant_mul_chk #(
  .WIDE_W(WIDE_W), .LANE_W(LANE_W), .OUT_REG(OUT_REG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode),
  .op_a(op_a), .op_b(op_b), .product(product)
);

// File: tb/dual_lane_mant_mul_tb_top.sv
`timescale 1ns/1ps
module dual_lane_mant_mul_tb_top;

  localparam int WW = 53;
  localparam int LW = 24;
  localparam int PW = 2 * WW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wideMode = 1'b0;
  logic [WW-1:0] opA = '0;
  logic [WW-1:0] opB = '0;
  logic [PW-1:0] product;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  dual_lane_mant_mul #(.WIDE_W(WW), .LANE_W(LW), .OUT_REG(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .wide_mode(wideMode),
    .op_a(opA), .op_b(opB), .product(product)
  );

  function automatic logic [PW-1:0] refProd(input logic m,
                                            input logic [WW-1:0] a,
                                            input logic [WW-1:0] b);
    logic [PW-1:0] r;
    logic [2*LW-1:0] lo, hi;
    if (m) return PW'(a) * PW'(b);
    lo = (2*LW)'(a[LW-1:0]) * (2*LW)'(b[LW-1:0]);
    hi = (2*LW)'(a[2*LW:LW+1]) * (2*LW)'(b[2*LW-1:LW]);
    r = '0;
    r[2*LW-1:0] = lo;
    r[4*LW:2*LW+1] = hi;
    return r;
  endfunction

  function automatic logic [WW-1:0] rnd53();
    return {21'($urandom), $urandom};
  endfunction

  task automatic check(input string req, input logic [PW-1:0] act,
                       input logic [PW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at falling edge, sample 1 ns after the next rising edge
  task automatic apply(input string req, input logic m,
                       input logic [WW-1:0] a, input logic [WW-1:0] b);
    @(negedge clk);
    wideMode = m; opA = a; opB = b;
    @(posedge clk); #1;
    check(req, product, refProd(m, a, b));
  endtask

  initial begin
    logic [WW-1:0] a, b, lanesOnly;
    logic [PW-1:0] held;
    void'($urandom(32'd4711));

    repeat (3) @(posedge clk);
    #1 check("R7 reset", product, '0);
    @(negedge clk) rst_n = 1'b1;

    // R1 directed
    apply("R1 ones", 1'b1, {WW{1'b1}}, {WW{1'b1}});
    apply("R1 zero", 1'b1, '0, {WW{1'b1}});
    apply("R1 msb", 1'b1, WW'(1) << (WW-1), WW'(1) << (WW-1));

    // R6 all-ones lanes: no leak across lanes
    a = '0; a[LW-1:0] = '1; a[2*LW:LW+1] = '1;
    b = '0; b[2*LW-1:0] = '1;
    apply("R6 lanes ones", 1'b0, a, b);
    check("R6 gap bit48", PW'(product[2*LW]), '0);
    check("R6 low field", PW'(product[2*LW-1:0]),
          PW'((2*LW)'({LW{1'b1}}) * (2*LW)'({LW{1'b1}})));

    // R5 ignored bits set to ones, lanes ones
    apply("R5 junk ones", 1'b0, {WW{1'b1}}, {WW{1'b1}});
    check("R4 gap high", PW'(product[PW-1:4*LW+1]), '0);

    // R7 hold between edges
    @(negedge clk);
    held = product;
    opA = rnd53(); opB = rnd53(); wideMode = ~wideMode;
    #1 check("R7 hold", product, held);

    // R8 alternating mode on consecutive cycles
    for (int k = 0; k < 16; k++) begin
      apply("R8 toggle", k[0], rnd53(), rnd53());
    end

    // Random mixes
    for (int k = 0; k < 300; k++) begin
      logic m;
      m = 1'($urandom);
      a = rnd53(); b = rnd53();
      apply(m ? "R1 rand" : "R2 R3 R4 rand", m, a, b);
      if (!m) begin
        // R5: clean copies with ignored bits cleared give same result
        lanesOnly = a; lanesOnly[LW] = 1'b0; lanesOnly[WW-1:2*LW+1] = '0;
        held = product;
        apply("R5 clean", 1'b0, lanesOnly, {5'b0, b[2*LW-1:0]});
        check("R5 equal", product, held);
      end
    end

    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (100000) @(posedge clk);
        failures++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule